// File: doc/BRIEF.md
# Error-Corrected Interleaved Data Scratchpad

This block is a tightly coupled data RAM for a processor load/store path. Storage is split into 2, 4 or 8 banks chosen by a parameter, and consecutive 32-bit words fall into consecutive banks. Every word is kept with seven check bits as a 39-bit entry. The check bits are computed when the word is written and tested again when it is read.

A single port carries a request strobe, a write enable, a byte address and write data. Reads return their data one cycle later. The response carries a flag for an error that was repaired and a flag for an error that could not be repaired.

A single flipped bit anywhere in the entry is repaired. Two flipped bits are detected and reported. An error-injection mask on the write path lets the system exercise both error flags without reaching into the storage.

Top module: `ecc_scratchpad`

## Requirements
- R1: Check bits c0..c5 are the XOR of the data bits selected by the masks 0x56AAAD5B (c0), 0x9B33366D (c1), 0xE3C3C78E (c2), 0x03FC07F0 (c3), 0x03FFF800 (c4) and 0xFC000000 (c5). A read of an entry written with a zero injection mask returns the written data with both error flags low.
- R2: Check bit c6 is the XOR of all 32 data bits and c0..c5. The entry holds data in bits 31:0 and c0..c6 in bits 38:32.
- R3: A read of an entry with exactly one flipped data bit returns the original data, with err_corr high and err_uncorr low.
- R4: A read of an entry with exactly one flipped check bit among c0..c5 (entry bits 37:32) returns the stored data unchanged, with err_corr high.
- R5: A read of an entry whose only flipped bit is c6 (entry bit 38) returns the data unchanged, with err_corr high and err_uncorr low.
- R6: A read of an entry with two flipped bits sets err_uncorr, clears err_corr and returns the stored data bits unmodified.
- R7: When a read is requested (req_valid=1, wr_en=0), rd_valid, rd_data and both flags present its result exactly on the next clock cycle.
- R8: In any cycle that does not follow a read request, rd_valid, rd_data and both flags are all zero.
- R9: Every distinct word address maps to its own entry. The bank is selected by the address bits directly above bit 1, and the row by the bits above the bank field.
- R10: Address bits 1:0 are ignored, so every access covers a full 32-bit word.
- R11: On a write, the 39-bit entry is stored XORed with wr_inject. A set bit in wr_inject flips the matching entry bit.
- R12: While reset is asserted, and right after it, rd_valid and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (10) | Byte address |
| wr_data | input | 32 | Write data |
| wr_inject | input | 39 | XOR mask applied to the stored entry on a write |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 32 | Read data, corrected where possible |
| err_corr | output | 1 | A single-bit error was repaired |
| err_uncorr | output | 1 | A double-bit error was detected |

## Verification
The bench injects errors at every one of the 39 entry positions, including c6 alone, where the syndrome is zero. A decoder that misread that case would flip data bit 0 or report a double error. Pairs of flipped bits are checked for passthrough: a design that tried to correct them would corrupt a data bit and raise the wrong flag. Writes to neighbouring words that differ in only the bank field or only the row field are read back, which catches bank aliasing. Reads are issued back-to-back and after writes, which catches a wrong response latency or stale flags leaking into idle cycles.

// File: rtl/ecc_scratchpad_pkg.sv
package ecc_scratchpad_pkg;

    localparam int DATA_W  = 32;
    localparam int CHECK_W = 7;
    localparam int ENTRY_W = DATA_W + CHECK_W;
    localparam int SYN_W   = 6;

    localparam logic [DATA_W-1:0] PARITY_MASK [SYN_W] = '{
        32'h56AA_AD5B, 32'h9B33_366D, 32'hE3C3_C78E,
        32'h03FC_07F0, 32'h03FF_F800, 32'hFC00_0000
    };

    function automatic logic [SYN_W-1:0] column_of(input int bitpos);
        logic [SYN_W-1:0] col;
        for (int k = 0; k < SYN_W; k++) col[k] = PARITY_MASK[k][bitpos];
        return col;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_scratchpad_pkg::*;
(
    input  logic [DATA_W-1:0]  data_i,
    output logic [ENTRY_W-1:0] entry_o
);
    logic [SYN_W-1:0] chk;

    always_comb begin
        for (int k = 0; k < SYN_W; k++) chk[k] = ^(data_i & PARITY_MASK[k]);
        entry_o = {^{data_i, chk}, chk, data_i};
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_scratchpad_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry_i,
    output logic [DATA_W-1:0]  data_o,
    output logic               corr_o,
    output logic               uncorr_o
);
    logic [DATA_W-1:0]  raw;
    logic [CHECK_W-1:0] chk;
    logic [SYN_W-1:0]   syn;
    logic               par_mis;
    logic [DATA_W-1:0]  flip;

    assign raw = entry_i[DATA_W-1:0];
    assign chk = entry_i[ENTRY_W-1:DATA_W];

    always_comb begin
        for (int k = 0; k < SYN_W; k++) syn[k] = ^(raw & PARITY_MASK[k]) ^ chk[k];
        par_mis = ^entry_i;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_locate
        assign flip[i] = par_mis && (syn == column_of(i));
    end

    assign data_o   = raw ^ flip;
    assign corr_o   = par_mis;
    assign uncorr_o = !par_mis && (syn != '0);
endmodule

// File: rtl/ecc_bank.sv
module ecc_bank
    import ecc_scratchpad_pkg::*;
#(
    parameter int ROWS  = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               en,
    input  logic               we,
    input  logic [ROW_W-1:0]   row,
    input  logic [ENTRY_W-1:0] wentry,
    output logic [ENTRY_W-1:0] rentry
);
    logic [ENTRY_W-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (en && we) store[row] <= wentry;
        if (en && !we) rentry <= store[row];
    end
endmodule

// File: rtl/ecc_scratchpad.sv
module ecc_scratchpad
    import ecc_scratchpad_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROWS  = 64,
    localparam int BSEL_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = 2 + BSEL_W + ROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wr_data,
    input  logic [38:0]        wr_inject,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic               err_corr,
    output logic               err_uncorr
);
    typedef struct packed {
        logic              rvld;
        logic [BSEL_W-1:0] bank;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    logic [BSEL_W-1:0]  bank_sel;
    logic [ROW_W-1:0]   row_sel;
    logic [ENTRY_W-1:0] enc_entry, wentry;
    logic [ENTRY_W-1:0] bank_out [BANKS];
    logic [ENTRY_W-1:0] rentry;
    logic [DATA_W-1:0]  dec_data;
    logic               dec_corr, dec_uncorr;
    logic               unused_byte_offset;

    assign bank_sel = addr[2 +: BSEL_W];
    assign row_sel  = addr[2 + BSEL_W +: ROW_W];
    assign unused_byte_offset = ^addr[1:0];

    ecc_encoder u_enc (.data_i(wr_data), .entry_o(enc_entry));
    assign wentry = enc_entry ^ wr_inject;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        ecc_bank #(.ROWS(ROWS)) u_bank (
            .clk    (clk),
            .en     (req_valid && (bank_sel == BSEL_W'(b))),
            .we     (wr_en),
            .row    (row_sel),
            .wentry (wentry),
            .rentry (bank_out[b])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.rvld = req_valid && !wr_en;
        if (req_valid && !wr_en) st_d.bank = bank_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rentry = bank_out[st_q.bank];

    ecc_decoder u_dec (
        .entry_i  (rentry),
        .data_o   (dec_data),
        .corr_o   (dec_corr),
        .uncorr_o (dec_uncorr)
    );

    assign rd_valid   = st_q.rvld;
    assign rd_data    = st_q.rvld ? dec_data : '0;
    assign err_corr   = st_q.rvld && dec_corr;
    assign err_uncorr = st_q.rvld && dec_uncorr;

    assert_rsp_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en) |=> rd_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !err_corr && !err_uncorr));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_uncorr));

    assert_uncorr_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_uncorr |-> (rd_data == rentry[DATA_W-1:0]));

    assert_corr_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr |-> ($countones(rd_data ^ rentry[DATA_W-1:0]) <= 1));

    assert_clean_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !err_corr && !err_uncorr) |-> (rd_data == rentry[DATA_W-1:0]));
endmodule

// File: tb/ecc_scratchpad_test.sv
`timescale 1ns/1ps
module ecc_scratchpad_test;
    localparam int BANKS = 4;
    localparam int ROWS  = 64;
    localparam int AW    = 2 + $clog2(BANKS) + $clog2(ROWS);
    localparam int WORDS = BANKS * ROWS;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [38:0] wr_inject = '0;
    logic rd_valid, err_corr, err_uncorr;
    logic [31:0] rd_data;

    int checks = 0, errors = 0;
    logic [38:0] model [int];
    bit exp_v = 0, exp_c = 0, exp_u = 0;
    logic [31:0] exp_d = '0;
    string exp_tag = "R8";

    always #2 clk = ~clk;

    ecc_scratchpad #(.BANKS(BANKS), .ROWS(ROWS)) uut (
        .clk, .rst_n, .req_valid, .wr_en, .addr, .wr_data, .wr_inject,
        .rd_valid, .rd_data, .err_corr, .err_uncorr
    );

    function automatic logic [38:0] encode(input logic [31:0] d);
        logic [31:0] m [6] = '{32'h56AA_AD5B, 32'h9B33_366D, 32'hE3C3_C78E,
                               32'h03FC_07F0, 32'h03FF_F800, 32'hFC00_0000};
        logic [5:0] c;
        for (int k = 0; k < 6; k++) c[k] = ^(d & m[k]);
        return {^{d, c}, c, d};
    endfunction

    function automatic bit is_code(input logic [38:0] e);
        return encode(e[31:0]) == e;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        check("R7 rd_valid", 64'(rd_valid), 64'(exp_v));
        check({exp_tag, " rd_data"}, 64'(rd_data), 64'(exp_d));
        check({exp_tag, " err_corr"}, 64'(err_corr), 64'(exp_c));
        check({exp_tag, " err_uncorr"}, 64'(err_uncorr), 64'(exp_u));
    endtask

    task automatic step(input bit v, input bit we, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [38:0] inj, input string tag);
        int idx;
        logic [38:0] e;
        @(negedge clk);
        compare();
        req_valid = v; wr_en = we; addr = a; wr_data = d; wr_inject = inj;
        idx = int'(a >> 2);
        exp_v = 0; exp_c = 0; exp_u = 0; exp_d = '0; exp_tag = "R8";
        if (v && we) model[idx] = encode(d) ^ inj;
        if (v && !we) begin
            e = model[idx];
            exp_v = 1; exp_tag = tag; exp_d = e[31:0];
            if (!is_code(e)) begin
                exp_u = 1;
                for (int j = 0; j < 39; j++) begin
                    if (is_code(e ^ (39'd1 << j))) begin
                        exp_u = 0; exp_c = 1; exp_d = (e ^ (39'd1 << j)) ;
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        check("R12 rd_valid in reset", 64'(rd_valid), 64'd0);
        check("R12 flags in reset", 64'({err_corr, err_uncorr}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R12 rd_valid after reset", 64'(rd_valid), 64'd0);

        // R9: fill every word with a pattern derived from its index
        for (int i = 0; i < WORDS; i++)
            step(1, 1, AW'(i << 2), 32'hA5C3_0000 ^ (i * 32'h0101_0107), '0, "R9");
        for (int i = 0; i < WORDS; i++)
            step(1, 0, AW'(i << 2), '0, '0, "R9");

        // R1/R2 clean patterns
        step(1, 1, AW'(4), 32'h0000_0000, '0, "R1"); step(1, 0, AW'(4), '0, '0, "R1");
        step(1, 1, AW'(4), 32'hFFFF_FFFF, '0, "R2"); step(1, 0, AW'(4), '0, '0, "R2");

        // R10: byte offset bits ignored
        step(1, 1, AW'(32'h21), 32'hDEAD_BEEF, '0, "R10");
        step(1, 0, AW'(32'h23), '0, '0, "R10");
        step(1, 0, AW'(32'h20), '0, '0, "R10");

        // R3, R4, R5, R11: every single-bit position
        for (int j = 0; j < 39; j++) begin
            step(1, 1, AW'(8), 32'h1357_9BDF + j, 39'd1 << j, "R11");
            step(1, 0, AW'(8), '0, '0, j < 32 ? "R3" : (j < 38 ? "R4" : "R5"));
        end

        // R6: pairs of flipped bits
        for (int j = 0; j < 39; j++) begin
            step(1, 1, AW'(12), 32'h2468_ACE0 ^ j, (39'd1 << j) | (39'd1 << ((j + 7) % 39)), "R6");
            step(1, 0, AW'(12), '0, '0, "R6");
        end

        // R7/R8: back-to-back reads, idles and mixed traffic
        for (int n = 0; n < 3000; n++) begin
            a = AW'($urandom_range(0, WORDS - 1) << 2) | AW'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: step(1, 1, a, $urandom, '0, "R1");
                1: step(1, 1, a, $urandom, 39'd1 << $urandom_range(0, 38), "R3");
                2: step(0, 0, a, $urandom, '0, "R8");
                default: step(1, 0, a, '0, '0, "R7");
            endcase
        end
        step(0, 0, '0, '0, '0, "R8");
        step(0, 0, '0, '0, '0, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule